// File: doc/BRIEF.md
# Sampling-Phase Sweep Calibrator

This block searches for a reliable capture phase for data read back from external memory. The right point to sample returning data is rarely the nominal quarter-cycle position. The data comes back after the clock has crossed the board twice, and it also carries the memory's own output delay. Rather than trusting a fixed offset, the calibrator measures where capture actually works.

After a start pulse, the block walks an external adjustable phase shifter down to the lowest allowed step. It then climbs one step at a time to the highest step. At every position it asks an external test engine for a pass/fail verdict. While the scan runs it keeps the longest contiguous run of passing positions. When the scan ends it steps the shifter back down to the middle of that run and raises a valid flag. If no position passed, it raises an error flag instead and leaves the shifter where the scan stopped.

The phase shifter moves one step per request, and every request is acknowledged. The calibrator keeps its own copy of the shifter's position, which assumes the shifter sits at step 0 when the block comes out of reset.

Top module: `phase_sweep_cal`

## Requirements
- R1: After reset, `calBusy`, `calValid`, `calError`, `psStep` and `testStart` are low, and `phaseNow` and `chosenPhase` are 0.
- R2: A `calStart` pulse while idle makes the block issue down-steps (`psDir`=0) until `phaseNow` equals `STEP_MIN`. `phaseNow` moves by one for each acknowledged step, in the requested direction.
- R3: At most one step request is outstanding: after a `psStep` pulse, no further `psStep` appears until `psDone` has been seen.
- R4: Exactly one test runs at each position from `STEP_MIN` up to `STEP_MAX`, in ascending order. A test never starts while a step is outstanding.
- R5: The block keeps the longest contiguous run of passing positions. When two runs have equal length, the one with the lower start position wins.
- R6: The chosen phase is the run start plus the run length divided by two, rounded down. After the scan the block steps down to that phase, sets `calValid`, and from then on `phaseNow` equals `chosenPhase`.
- R7: If no position passes, `calError` goes high, `calValid` stays low, and the shifter is left at `STEP_MAX`. `calValid` and `calError` are never high together.
- R8: A `calStart` pulse while a calibration is running has no effect: the scan continues without restarting.
- R9: `phaseNow` never leaves the range `STEP_MIN` to `STEP_MAX`, and no up-step is requested at `STEP_MAX`.
- R10: A new calibration clears `calValid` and `calError` on the cycle it starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| calStart | input | 1 | One-cycle request to begin a calibration |
| psStep | output | 1 | One-cycle request to move the phase shifter one step |
| psDir | output | 1 | Step direction, valid with `psStep`: 1 = up, 0 = down |
| psDone | input | 1 | Shifter acknowledges that the requested step is complete |
| testStart | output | 1 | One-cycle request to run a capture test at the current phase |
| testDone | input | 1 | Test engine reports that the test has finished |
| testPass | input | 1 | Test verdict, valid with `testDone` |
| calBusy | output | 1 | High while a calibration is in progress |
| calValid | output | 1 | Calibration succeeded and the shifter is at `chosenPhase` |
| calError | output | 1 | Calibration found no passing phase |
| chosenPhase | output | PW | Selected phase (signed) |
| phaseNow | output | PW | Tracked current shifter position (signed) |

## Verification
A corrupted run length or run start would show up at the end of the scan. `chosenPhase` would then disagree with the midpoint computed from the pass pattern, and the shifter model would settle on the wrong step. This is visible the cycle `calBusy` falls. A position counter that drifts from the real shifter shows at once as a skipped or repeated test position, or as a mismatch between `phaseNow` and the shifter model when the run ends. Sweeping every possible single passing window, together with several multi-window and empty patterns, makes rounding, tie-breaking and edge-of-range faults visible within one calibration.

// File: rtl/psc_pkg.sv
package psc_pkg;
  // Strobes from the sequencing control to the position/window datapath.
  typedef struct packed {
    logic clrWin;      // forget all window history
    logic stepUp;      // shifter confirmed one step up
    logic stepDown;    // shifter confirmed one step down
    logic record;      // a test verdict is present on testPass
    logic latchTarget; // capture the midpoint of the best run
  } psc_strobes_t;
endpackage

// File: rtl/psc_datapath.sv
module psc_datapath import psc_pkg::*; #(
  parameter int PW       = 6,
  parameter int STEP_MIN = -8,
  parameter int STEP_MAX = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  psc_strobes_t         strb,
  input  logic                 testPass,
  output logic                 atMin,
  output logic                 atMax,
  output logic                 atTarget,
  output logic                 anyPass,
  output logic signed [PW-1:0] phasePos,
  output logic signed [PW-1:0] chosenPhase
);
  localparam int SPAN = STEP_MAX - STEP_MIN + 1;
  localparam int LW   = $clog2(SPAN + 1);
  localparam logic signed [PW-1:0] MIN_S = PW'(STEP_MIN);
  localparam logic signed [PW-1:0] MAX_S = PW'(STEP_MAX);
  localparam logic signed [PW-1:0] ONE_S = PW'(1);

  logic signed [PW-1:0] runStart;
  logic signed [PW-1:0] bestStart;
  logic [LW-1:0]        runLen;
  logic [LW-1:0]        bestLen;
  logic [LW-1:0]        runNext;

  assign runNext  = runLen + LW'(1);
  assign atMin    = (phasePos == MIN_S);
  assign atMax    = (phasePos == MAX_S);
  assign atTarget = (phasePos == chosenPhase);
  assign anyPass  = (bestLen != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phasePos    <= '0;
      runStart    <= '0;
      runLen      <= '0;
      bestStart   <= '0;
      bestLen     <= '0;
      chosenPhase <= '0;
    end else begin
      if (strb.stepUp)        phasePos <= phasePos + ONE_S;
      else if (strb.stepDown) phasePos <= phasePos - ONE_S;

      if (strb.clrWin) begin
        runStart  <= '0;
        runLen    <= '0;
        bestStart <= '0;
        bestLen   <= '0;
      end else if (strb.record) begin
        if (testPass) begin
          runLen <= runNext;
          if (runLen == '0) runStart <= phasePos;
          // strict compare: an equal later run does not displace the earlier one
          if (runNext > bestLen) begin
            bestLen   <= runNext;
            bestStart <= (runLen == '0) ? phasePos : runStart;
          end
        end else begin
          runLen <= '0;
        end
      end

      if (strb.latchTarget) chosenPhase <= bestStart + PW'(bestLen >> 1);
    end
  end

  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (phasePos >= MIN_S) && (phasePos <= MAX_S)); // R9
  AST_NO_UP_AT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepUp |-> !atMax); // R9
  AST_PASS_REMEMBERED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.record && testPass && !strb.clrWin) |=> anyPass); // R5
endmodule

// File: rtl/psc_control.sv
module psc_control import psc_pkg::*; (
  input  logic         clk,
  input  logic         rstN,
  input  logic         calStart,
  input  logic         psDone,
  input  logic         testDone,
  input  logic         atMin,
  input  logic         atMax,
  input  logic         atTarget,
  input  logic         anyPass,
  output psc_strobes_t strb,
  output logic         psStep,
  output logic         psDir,
  output logic         testStart,
  output logic         calBusy,
  output logic         calValid,
  output logic         calError
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_SEEK, ST_SEEK_W, ST_TGO, ST_TWAIT,
    ST_ADV, ST_ADV_W, ST_DECIDE, ST_RET, ST_RET_W
  } state_t;

  state_t state, nxt;

  always_comb begin
    strb      = '0;
    psStep    = 1'b0;
    psDir     = 1'b0;
    testStart = 1'b0;
    nxt       = state;
    unique case (state)
      ST_IDLE:   if (calStart) begin strb.clrWin = 1'b1; nxt = ST_SEEK; end
      ST_SEEK:   if (atMin) nxt = ST_TGO;
                 else begin psStep = 1'b1; nxt = ST_SEEK_W; end
      ST_SEEK_W: if (psDone) begin strb.stepDown = 1'b1; nxt = ST_SEEK; end
      ST_TGO:    begin testStart = 1'b1; nxt = ST_TWAIT; end
      ST_TWAIT:  if (testDone) begin
                   strb.record = 1'b1;
                   nxt = atMax ? ST_DECIDE : ST_ADV;
                 end
      ST_ADV:    begin psStep = 1'b1; psDir = 1'b1; nxt = ST_ADV_W; end
      ST_ADV_W:  if (psDone) begin strb.stepUp = 1'b1; nxt = ST_TGO; end
      ST_DECIDE: if (anyPass) begin strb.latchTarget = 1'b1; nxt = ST_RET; end
                 else nxt = ST_IDLE;
      ST_RET:    if (atTarget) nxt = ST_IDLE;
                 else begin psStep = 1'b1; nxt = ST_RET_W; end
      ST_RET_W:  if (psDone) begin strb.stepDown = 1'b1; nxt = ST_RET; end
      default:   nxt = ST_IDLE;
    endcase
  end

  assign calBusy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      calValid <= 1'b0;
      calError <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && calStart) begin
        calValid <= 1'b0;
        calError <= 1'b0;
      end else if (state == ST_DECIDE && !anyPass) begin
        calError <= 1'b1;
      end else if (state == ST_RET && atTarget) begin
        calValid <= 1'b1;
      end
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (calBusy && calStart && state != ST_DECIDE && !(state == ST_RET && atTarget))
    |=> calBusy); // R8
  AST_SEEK_GOES_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (psStep && state == ST_SEEK) |-> !psDir); // R2
  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (!calBusy && calStart) |=> (!calValid && !calError)); // R10
endmodule

// File: rtl/phase_sweep_cal.sv
module phase_sweep_cal import psc_pkg::*; #(
  parameter int PW       = 6,
  parameter int STEP_MIN = -8,
  parameter int STEP_MAX = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 calStart,
  output logic                 psStep,
  output logic                 psDir,
  input  logic                 psDone,
  output logic                 testStart,
  input  logic                 testDone,
  input  logic                 testPass,
  output logic                 calBusy,
  output logic                 calValid,
  output logic                 calError,
  output logic signed [PW-1:0] chosenPhase,
  output logic signed [PW-1:0] phaseNow
);
  psc_strobes_t strb;
  logic atMin, atMax, atTarget, anyPass;

  psc_control u_ctrl (
    .clk(clk), .rstN(rstN), .calStart(calStart), .psDone(psDone),
    .testDone(testDone), .atMin(atMin), .atMax(atMax), .atTarget(atTarget),
    .anyPass(anyPass), .strb(strb), .psStep(psStep), .psDir(psDir),
    .testStart(testStart), .calBusy(calBusy), .calValid(calValid),
    .calError(calError)
  );

  psc_datapath #(.PW(PW), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .testPass(testPass),
    .atMin(atMin), .atMax(atMax), .atTarget(atTarget), .anyPass(anyPass),
    .phasePos(phaseNow), .chosenPhase(chosenPhase)
  );

  // Port-level tracking of an unanswered step request.
  logic stepPending;
  always_ff @(posedge clk) begin
    if (!rstN)       stepPending <= 1'b0;
    else if (psStep) stepPending <= 1'b1;
    else if (psDone) stepPending <= 1'b0;
  end

  AST_ONE_STEP_OUT: assert property (@(posedge clk) disable iff (!rstN)
    stepPending |-> !psStep); // R3
  AST_TEST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    testStart |-> (!stepPending && !psStep)); // R4
  AST_VALID_AT_CHOICE: assert property (@(posedge clk) disable iff (!rstN)
    calValid |-> (phaseNow == chosenPhase)); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(calValid && calError)); // R7
endmodule

// File: tb/phase_sweep_cal_tb.sv
module phase_sweep_cal_tb;
  localparam int PW = 6;
  localparam int MINP = -8;
  localparam int MAXP = 7;
  localparam int SPAN = MAXP - MINP + 1;

  logic clk = 0;
  logic rstN = 0;
  logic calStart = 0;
  logic psStep, psDir, testStart, calBusy, calValid, calError;
  logic psDone = 0, testDone = 0, testPass = 0;
  logic signed [PW-1:0] chosenPhase, phaseNow;

  int checks = 0, failures = 0, cycles = 0;
  logic [SPAN-1:0] passMask = '0;
  logic mdlClr = 0;

  // behavioural shifter / test engine state
  int modelPhase = 0, sCnt = 0, tCnt = 0, dlyA = 1, dlyB = 2;
  int testsRun = 0, orderErr = 0, expectNext = MINP, rangeErr = 0;
  logic sDir = 0;

  always #10 clk = ~clk;

  phase_sweep_cal #(.PW(PW), .STEP_MIN(MINP), .STEP_MAX(MAXP)) u_dut (
    .clk(clk), .rstN(rstN), .calStart(calStart), .psStep(psStep), .psDir(psDir),
    .psDone(psDone), .testStart(testStart), .testDone(testDone), .testPass(testPass),
    .calBusy(calBusy), .calValid(calValid), .calError(calError),
    .chosenPhase(chosenPhase), .phaseNow(phaseNow)
  );

  always @(posedge clk) begin
    psDone   <= 1'b0;
    testDone <= 1'b0;
    if (!rstN) begin
      modelPhase <= 0; sCnt <= 0; tCnt <= 0;
    end else begin
      if (psStep) begin
        if (sCnt != 0 || tCnt != 0) orderErr <= orderErr + 1;
        sCnt <= dlyA; sDir <= psDir;
        dlyA <= (dlyA % 3) + 1;
      end else if (sCnt == 1) begin
        psDone <= 1'b1;
        if ((sDir && modelPhase >= MAXP) || (!sDir && modelPhase <= MINP))
          rangeErr <= rangeErr + 1;
        modelPhase <= sDir ? modelPhase + 1 : modelPhase - 1;
        sCnt <= 0;
      end else if (sCnt > 1) sCnt <= sCnt - 1;

      if (mdlClr) begin
        testsRun <= 0; orderErr <= 0; rangeErr <= 0; expectNext <= MINP;
      end else if (testStart) begin
        if (modelPhase != expectNext || sCnt != 0) orderErr <= orderErr + 1;
        expectNext <= modelPhase + 1;
        testsRun <= testsRun + 1;
        tCnt <= dlyB; dlyB <= (dlyB % 4) + 1;
      end else if (tCnt == 1) begin
        testDone <= 1'b1;
        testPass <= passMask[modelPhase - MINP];
        tCnt <= 0;
      end else if (tCnt > 1) tCnt <= tCnt - 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired: actual cycles=%0d expected < 190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // poke: 0 none, >0 issue a second calStart after that many cycles
  task automatic runCal(input logic [SPAN-1:0] mask, input int poke);
    int run = 0, rs = 0, bestS = 0, bestL = 0, target;
    for (int i = 0; i < SPAN; i++) begin
      if (mask[i]) begin
        if (run == 0) rs = i;
        run = run + 1;
        if (run > bestL) begin bestL = run; bestS = rs; end
      end else run = 0;
    end
    target = MINP + bestS + bestL / 2;
    @(negedge clk);
    passMask = mask; mdlClr = 1;
    @(negedge clk);
    mdlClr = 0; calStart = 1;
    @(negedge clk);
    calStart = 0;
    chk("R10 valid cleared at start", int'(calValid), 0);
    chk("R10 error cleared at start", int'(calError), 0);
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      calStart = 1;
      @(negedge clk);
      calStart = 0;
    end
    while (calBusy) @(negedge clk);
    chk("R4 one test per position", testsRun, SPAN);
    chk(poke > 0 ? "R8 ordered scan despite extra start" : "R4 ascending order, no test during step",
        orderErr, 0);
    chk("R9 shifter kept in range", rangeErr, 0);
    chk("R2 tracked phase equals shifter", int'(phaseNow), modelPhase);
    if (bestL == 0) begin
      chk("R7 error flag", int'(calError), 1);
      chk("R7 valid low", int'(calValid), 0);
      chk("R7 left at top", modelPhase, MAXP);
    end else begin
      chk("R6 valid flag", int'(calValid), 1);
      chk("R7 error low", int'(calError), 0);
      chk("R5 R6 chosen phase", int'(chosenPhase), target);
      chk("R6 shifter at choice", modelPhase, target);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 busy", int'(calBusy), 0);
    chk("R1 valid", int'(calValid), 0);
    chk("R1 error", int'(calError), 0);
    chk("R1 step", int'(psStep), 0);
    chk("R1 test", int'(testStart), 0);
    chk("R1 phase", int'(phaseNow), 0);
    chk("R1 chosen", int'(chosenPhase), 0);

    runCal(16'h0000, 0);                 // R7 nothing passes
    runCal(16'hFFFF, 0);                 // full range
    runCal(16'b0001_1111_0000_1110, 0);  // R5 later run longer
    runCal(16'b0000_1110_0011_1111, 0);  // R5 earlier run longer
    runCal(16'b0001_1100_0001_1100, 0);  // R5 tie keeps lower start
    runCal(16'b0000_0000_0000_0000, 0);  // R7 again, from a non-zero phase
    runCal(16'b0000_0111_1100_0000, 9);  // R8 start while busy
    runCal(16'b0011_1000_0000_0000, 40); // R8 start while busy, later
    for (int s = 0; s < SPAN; s++)
      for (int e = s; e < SPAN; e++)
        runCal(SPAN'(((1 << (e - s + 1)) - 1) << s), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule